// File: doc/BRIEF.md
# Mask-Level-Event Interrupt Aggregator

This block merges up to 31 interrupt source lines into one sticky CPU interrupt request. Sources do not arrive as raw wires. Each cycle the block receives a vector that flags which sources have reported a new line state, together with the new state of each of those sources. For every source the block keeps its last known line level and a pending-event bit. The pending bit is gated by an enable mask. One CPU request latch goes up when pending events exist and comes down only when software acknowledges them.

Software reaches the block through a small 32-bit register port. The port has no read strobe, and reads have no side effects. There are four word slots: mask, level, event and clear. Bit 31 of the mask word is a mode bit that picks the capture rule. When it is 0, events are captured on a rising edge only. When it is 1, every reported change is captured. Every value that crosses the bus is byte-swapped, so the registers appear little-endian to a big-endian master.

Top module: `mle_irq_aggregator`

## Requirements
- R1: Reads are combinational and decode only address bits 3:2, so bits 1:0 are ignored. Word 0 returns the mask, word 1 returns the levels, word 2 returns the events, and word 3 returns zero. Register bit n holding source n sits in bits 30:0, and bit 31 is zero except in the mask word. The bus word equals the register with its four bytes reversed: register bits 31:24 appear on bus bits 7:0.
- R2: A write to word 0 stores the byte-reversed bus value as the mask. Register bit 31 is the mode bit, and bits 30:0 enable sources 0 to 30. A mask write leaves the events and levels unchanged.
- R3: With the mode bit at 0, a report for a source sets its event bit only if the reported level is 1 and the stored level is 0. Any other report for that source clears its event bit.
- R4: With the mode bit at 1, any report for a source sets its event bit, whatever level is reported.
- R5: In a cycle with at least one report, the event register is ANDed with the mask after capture, so disabled sources are never left pending.
- R6: For each reported source, the level register takes the reported level at the same clock edge. Sources that were not reported keep their level.
- R7: A write to word 3 with the mode bit at 1 and register bit 31 of the written value at 1 zeroes the whole event register.
- R8: Any other write to word 3 clears each event bit whose written register bit is 1. Register bit 31 never clears an event by itself.
- R9: If the event register is nonzero after a cycle with reports, cpu_irq is 1 from the next clock edge.
- R10: cpu_irq falls only after a write to word 3 that leaves the event register at zero. Events that reach zero through reports alone keep cpu_irq high.
- R11: When a clear write and reports fall in the same cycle, the clear is applied first and capture second. A new event on a bit being cleared survives and can hold cpu_irq high. A mask write in the same cycle takes effect only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_chg | input | NUM_SRC | Per-source report strobe for this cycle |
| src_lvl | input | NUM_SRC | Reported line level, valid where src_chg is 1 |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, byte-reversed |
| bus_rdata | output | 32 | Read data, byte-reversed, combinational |
| cpu_irq | output | 1 | Sticky CPU interrupt request |

## Verification
The bench first targets the latch corners. A source that falls in rising-edge mode empties the event register without a clear write, and a design that releases on that would drop cpu_irq early. A clear write in the same cycle as a new rising report on the same bit must keep the event; clearing after capture would lose it. The clear-all bit is tried in both modes, since honouring it in rising-edge mode would wipe every event. A masked rising report must still update the level while staying non-pending. Reads with nonzero low address bits and every bus value go through an independent byte-swap model, which exposes a missing or wrong lane swap.

// File: rtl/mle_pkg.sv
package mle_pkg;
  localparam int WORD_W     = 32;
  localparam int MODE_BIT   = 31;
  localparam int CLRALL_BIT = 31;

  typedef enum logic [1:0] {
    SEL_MASK  = 2'd0,
    SEL_LEVEL = 2'd1,
    SEL_EVENT = 2'd2,
    SEL_CLEAR = 2'd3
  } reg_sel_e;

  // Reverse the four byte lanes of a bus word.
  function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  // Capture rule for one reported source.
  function automatic logic capture_bit(input logic any_mode, input logic new_lvl,
                                       input logic old_lvl);
    return any_mode | (new_lvl & ~old_lvl);
  endfunction
endpackage

// File: rtl/mle_bus_if.sv
module mle_bus_if
  import mle_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [WORD_W-1:0]  bus_wdata,
  output logic [WORD_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] levels_q,
  input  logic [NUM_SRC-1:0] events_q,
  output logic [NUM_SRC-1:0] mask_en,
  output logic               mode_any,
  output logic               clr_wr,
  output logic               clr_all,
  output logic [NUM_SRC-1:0] clr_bits
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] wval;
  logic [WORD_W-1:0] rword;
  logic              mask_wr;

  assign idx      = bus_addr[ADDR_W-1:2];
  assign wval     = lane_swap(bus_wdata);
  assign mask_wr  = bus_wr && (idx == IDX_W'(SEL_MASK));
  assign clr_wr   = bus_wr && (idx == IDX_W'(SEL_CLEAR));
  assign clr_all  = wval[CLRALL_BIT];
  assign clr_bits = wval[NUM_SRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_en  <= '0;
      mode_any <= 1'b0;
    end else if (mask_wr) begin
      mask_en  <= wval[NUM_SRC-1:0];
      mode_any <= wval[MODE_BIT];
    end
  end

  always_comb begin
    rword = '0;
    if (idx == IDX_W'(SEL_MASK)) begin
      rword[NUM_SRC-1:0] = mask_en;
      rword[MODE_BIT]    = mode_any;
    end else if (idx == IDX_W'(SEL_LEVEL)) begin
      rword[NUM_SRC-1:0] = levels_q;
    end else if (idx == IDX_W'(SEL_EVENT)) begin
      rword[NUM_SRC-1:0] = events_q;
    end
  end

  assign bus_rdata = lane_swap(rword);

  assert_mask_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mode_any == $past(wval[MODE_BIT])) && (mask_en == $past(wval[NUM_SRC-1:0])));
endmodule

// File: rtl/mle_event_core.sv
module mle_event_core
  import mle_pkg::*;
#(
  parameter int NUM_SRC = 31
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_chg,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [NUM_SRC-1:0] mask_en,
  input  logic               mode_any,
  input  logic               clr_wr,
  input  logic               clr_all,
  input  logic [NUM_SRC-1:0] clr_bits,
  output logic [NUM_SRC-1:0] events_q,
  output logic [NUM_SRC-1:0] levels_q,
  output logic               upd,
  output logic               ev_next_nz,
  output logic               ev_clr_zero
);
  logic [NUM_SRC-1:0] ev_c;
  logic [NUM_SRC-1:0] ev_s;
  logic [NUM_SRC-1:0] ev_n;
  logic [NUM_SRC-1:0] lv_n;

  // Step 1: acknowledge.
  always_comb begin
    ev_c = events_q;
    if (clr_wr) begin
      if (mode_any && clr_all) ev_c = '0;
      else                     ev_c = events_q & ~clr_bits;
    end
  end

  // Step 2: per-source capture on top of the acknowledged value.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign ev_s[i] = src_chg[i] ? capture_bit(mode_any, src_lvl[i], levels_q[i]) : ev_c[i];
    assign lv_n[i] = src_chg[i] ? src_lvl[i] : levels_q[i];
  end

  assign upd         = |src_chg;
  assign ev_n        = upd ? (ev_s & mask_en) : ev_c;
  assign ev_next_nz  = |ev_n;
  assign ev_clr_zero = (ev_c == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      events_q <= '0;
      levels_q <= '0;
    end else begin
      events_q <= ev_n;
      levels_q <= lv_n;
    end
  end

  assert_masked_gone_R5: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ((events_q & ~$past(mask_en)) == '0));
  assert_level_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (((levels_q ^ $past(src_lvl)) & $past(src_chg)) == '0));
  assert_set_only_reported_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> ((events_q & ~$past(events_q) & ~$past(src_chg)) == '0));
  assert_any_change_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_any && upd) |=> ((~events_q & $past(src_chg) & $past(mask_en)) == '0));
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && clr_all && mode_any && !upd) |=> (events_q == '0));
endmodule

// File: rtl/mle_cpu_latch.sv
module mle_cpu_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic ev_next_nz,
  input  logic clr_wr,
  input  logic ev_clr_zero,
  output logic irq_q
);
  logic set_req;
  logic rel_req;

  assign set_req = upd & ev_next_nz;
  assign rel_req = clr_wr & ev_clr_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= set_req | (irq_q & ~rel_req);
  end

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> irq_q);
  assert_irq_release_only_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(clr_wr));
endmodule

// File: rtl/mle_irq_aggregator.sv
module mle_irq_aggregator
  import mle_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_chg,
  input  logic [NUM_SRC-1:0] src_lvl,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               cpu_irq
);
  logic [NUM_SRC-1:0] mask_en;
  logic               mode_any;
  logic               clr_wr;
  logic               clr_all;
  logic [NUM_SRC-1:0] clr_bits;
  logic [NUM_SRC-1:0] events_q;
  logic [NUM_SRC-1:0] levels_q;
  logic               upd;
  logic               ev_next_nz;
  logic               ev_clr_zero;

  mle_bus_if #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .levels_q(levels_q),
    .events_q(events_q), .mask_en(mask_en), .mode_any(mode_any),
    .clr_wr(clr_wr), .clr_all(clr_all), .clr_bits(clr_bits)
  );

  mle_event_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk(clk), .rst_n(rst_n), .src_chg(src_chg), .src_lvl(src_lvl),
    .mask_en(mask_en), .mode_any(mode_any), .clr_wr(clr_wr), .clr_all(clr_all),
    .clr_bits(clr_bits), .events_q(events_q), .levels_q(levels_q), .upd(upd),
    .ev_next_nz(ev_next_nz), .ev_clr_zero(ev_clr_zero)
  );

  mle_cpu_latch u_latch (
    .clk(clk), .rst_n(rst_n), .upd(upd), .ev_next_nz(ev_next_nz),
    .clr_wr(clr_wr), .ev_clr_zero(ev_clr_zero), .irq_q(cpu_irq)
  );

  // Same-cycle acknowledge and report: a fresh event on an acknowledged bit survives.
  assert_clear_then_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && upd && ev_next_nz) |=> cpu_irq);
endmodule

// File: tb/mle_irq_aggregator_tb.sv
`timescale 1ns/1ps
module mle_irq_aggregator_tb;
  localparam int NS = 31;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_chg = '0;
  logic [NS-1:0] src_lvl = '0;
  logic [3:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          cpu_irq;

  int checks = 0;
  int errors = 0;

  // Reference state.
  logic [NS-1:0] m_mask = '0;
  logic          m_mode = 1'b0;
  logic [NS-1:0] m_lvl  = '0;
  logic [NS-1:0] m_ev   = '0;
  logic          m_irq  = 1'b0;

  always #2.5 clk = ~clk;

  mle_irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .src_chg(src_chg), .src_lvl(src_lvl),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  function automatic logic [31:0] bswap(input logic [31:0] v);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = v[8*(3-b) +: 8];
    return r;
  endfunction

  task automatic chk(input string what, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [1:0] word, input logic [1:0] low,
                        input logic [31:0] exp_reg, input string tag);
    bus_addr = {word, low};
    #0.2;
    chk($sformatf("read word %0d", word), tag, bus_rdata, bswap(exp_reg));
  endtask

  task automatic check_all(input string tag, input logic [1:0] low);
    rd_chk(2'd0, low, {m_mode, m_mask}, tag);
    rd_chk(2'd1, low, {1'b0, m_lvl}, tag);
    rd_chk(2'd2, low, {1'b0, m_ev}, tag);
    rd_chk(2'd3, low, 32'h0, tag);
    checks++;
    if (cpu_irq !== m_irq) begin
      errors++;
      $display("FAIL %s cpu_irq actual=%b expected=%b", tag, cpu_irq, m_irq);
    end
  endtask

  // One clock with the given stimulus; reference updated from the requirements.
  task automatic step(input logic [NS-1:0] chg, input logic [NS-1:0] lvl, input logic wr,
                      input logic [1:0] word, input logic [31:0] reg_val, input string tag);
    logic [NS-1:0] ev;
    logic rel, setq;
    ev = m_ev; rel = 1'b0; setq = 1'b0;
    @(negedge clk);
    src_chg = chg; src_lvl = lvl; bus_wr = wr;
    bus_addr = {word, 2'($urandom_range(0, 3))}; bus_wdata = bswap(reg_val);
    if (wr && word == 2'd3) begin            // R8 / R7: acknowledge first
      if (m_mode && reg_val[31]) ev = '0;
      else ev = ev & ~reg_val[NS-1:0];
      rel = (ev == '0);
    end
    if (chg != '0) begin                      // R3 / R4 / R5 capture second (R11)
      for (int i = 0; i < NS; i++)
        if (chg[i]) ev[i] = m_mode || (lvl[i] && !m_lvl[i]);
      ev = ev & m_mask;
      setq = (ev != '0);
    end
    for (int i = 0; i < NS; i++) if (chg[i]) m_lvl[i] = lvl[i];   // R6
    m_ev = ev;
    if (setq) m_irq = 1'b1;
    else if (rel) m_irq = 1'b0;                // R9 / R10
    if (wr && word == 2'd0) begin m_mask = reg_val[NS-1:0]; m_mode = reg_val[31]; end
    @(posedge clk);
    #0.5;
    src_chg = '0; bus_wr = 1'b0;
    check_all(tag, 2'($urandom_range(0, 3)));
  endtask

  localparam logic [NS-1:0] B4 = NS'(1) << 4;
  localparam logic [NS-1:0] B5 = NS'(1) << 5;

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7315));
    repeat (3) @(posedge clk);
    #0.5 rst_n = 1'b1;
    check_all("R1 reset", 2'd0);
    rd_chk(2'd0, 2'd3, 32'h0, "R1 low bits");

    step('0, '0, 1'b1, 2'd0, 32'h0000_0030, "R2 mask write");
    step(B4, B4, 1'b0, 2'd0, 32'h0, "R3 R9 rising");
    step(B4, '0, 1'b0, 2'd0, 32'h0, "R3 R10 falling no release");
    step(B4, '0, 1'b0, 2'd0, 32'h0, "R3 repeat low");
    step('0, '0, 1'b1, 2'd3, 32'h0, "R10 clear write releases");
    step(B4, B4, 1'b0, 2'd0, 32'h0, "R3 set again");
    step(B4, B4, 1'b0, 2'd0, 32'h0, "R3 high stays high clears");
    step('0, '0, 1'b1, 2'd3, 32'h0, "R10 release");
    step(B5 << 2, B5 << 2, 1'b0, 2'd0, 32'h0, "R5 R6 masked rising");
    step('0, '0, 1'b1, 2'd0, 32'h8000_0030, "R2 mode any");
    step(B4, '0, 1'b0, 2'd0, 32'h0, "R4 falling sets");
    step(B5, '0, 1'b0, 2'd0, 32'h0, "R4 no level change sets");
    step('0, '0, 1'b1, 2'd3, 32'h8000_0000, "R7 clear all");
    step('0, '0, 1'b1, 2'd0, 32'h0000_0030, "R2 edge mode");
    step(B4, B4, 1'b0, 2'd0, 32'h0, "R3 rising");
    step('0, '0, 1'b1, 2'd3, 32'h8000_0000, "R8 bit31 ignored");
    step('0, '0, 1'b1, 2'd3, {1'b0, B5}, "R8 other bit");
    step(B4, '0, 1'b0, 2'd0, 32'h0, "R10 fall keeps irq");
    step(B4, B4, 1'b1, 2'd3, {1'b0, B4}, "R11 clear and rise");
    step(B4, '0, 1'b1, 2'd0, 32'h0, "R11 mask write same cycle");
    step('0, '0, 1'b1, 2'd3, 32'h7FFF_FFFF, "R8 clear rest");

    for (int n = 0; n < 3000; n++) begin
      logic [NS-1:0] c, l;
      logic w;
      logic [1:0] wd;
      logic [31:0] v;
      c  = NS'($urandom & $urandom & $urandom);
      if ($urandom_range(0, 2) == 0) c = '0;
      l  = NS'($urandom);
      w  = ($urandom_range(0, 3) == 0);
      wd = 2'($urandom_range(0, 3));
      v  = $urandom;
      if (wd == 2'd3 && $urandom_range(0, 1) == 1) v = v & 32'h8000_00FF;
      step(c, l, w, wd, v, "R1 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule